// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns timing strobes from a real-time clock core into a periodic event. A 2-bit period field picks one of four strobe sources: a 64 Hz tick, a one-second tick, the minute carry or the hour carry. Each selected strobe raises an event flag. Software sees the flag in the status register, and the flag also drives an interrupt pin.

A mode bit sets how the flag behaves. In latched mode the flag stays set until software clears it by writing a zero to its bit. In pulse mode the flag clears by itself after a fixed number of clock cycles. A mask bit holds the pin low without stopping the flag. The block does not generate the base strobes; it only consumes them. It is reached through a small register port with one select bit. The status register sits at select 0 and the control register at select 1.

Top module: `periodic_irq_gen`

## Requirements
- R1: Control bits 3:2 pick the event source: 00 the 64 Hz tick, 01 the one-second tick, 10 the minute carry, 11 the hour carry. A strobe on any source not selected leaves the flag unchanged. The flag rises only in the cycle after a selected strobe.
- R2: With control bit 1 at 0 (latched mode), the flag stays set until a status write (select 0) carries 0 in bit 2. A status write with bit 2 at 1 leaves the flag set.
- R3: With control bit 1 at 1 (pulse mode), the flag is high for exactly PULSE_CYCLES clock cycles after a selected strobe and then clears without software action.
- R4: With control bit 0 at 1, irq_out stays low while the flag still sets. With bit 0 at 0, irq_out equals the flag in the same cycle.
- R5: A read of select 0 returns the flag in bit 2 and zeros elsewhere. A read of select 1 returns the last value written to the control register. rdata updates one cycle after rd_en.
- R6: A strobe in the same cycle as a control register write is dropped. Counting resumes with the next matching strobe after the write.
- R7: When a selected strobe and a flag-clearing status write fall in the same cycle, the flag ends up set.
- R8: After reset the control register reads 0, the flag is 0 and irq_out is 0.
- R9: A selected strobe during an active pulse restarts the full PULSE_CYCLES width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_64hz | input | 1 | One-cycle 64 Hz strobe |
| tick_sec | input | 1 | One-cycle one-second strobe |
| carry_min | input | 1 | One-cycle minute carry strobe |
| carry_hour | input | 1 | One-cycle hour carry strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects control |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data |
| irq_out | output | 1 | Interrupt or pulse output |

## Verification
Two functions can meet in one cycle: a selected strobe setting the flag, and a status write clearing it. The bench forces both into the same clock edge and expects the flag and irq_out to end up set. A clear alone in the next cycle must then drop them. A second pairing is also exercised: a control write and a strobe in the same edge. The bench checks that the strobe is dropped and that the next matching strobe is counted.

// File: rtl/pig_pkg.sv
package pig_pkg;
  typedef enum logic [1:0] {
    SRC_64HZ = 2'b00,
    SRC_SEC  = 2'b01,
    SRC_MIN  = 2'b10,
    SRC_HOUR = 2'b11
  } src_e;

  typedef struct packed {
    src_e period;
    logic pulse_mode;
    logic mask;
  } ctl_t;

  localparam int unsigned REG_W = 4;
  localparam int unsigned FLAG_BIT = 2;
endpackage

// File: rtl/pig_tick_select.sv
module pig_tick_select
  import pig_pkg::*;
#(
  parameter int unsigned NSRC = 4
) (
  input  logic            ctl_wr,
  input  src_e            period,
  input  logic [NSRC-1:0] ticks,
  output logic            evt
);
  always_comb begin
    evt = ticks[period] & ~ctl_wr;
  end
endmodule

// File: rtl/pig_flag_core.sv
module pig_flag_core #(
  parameter int unsigned PULSE_CYCLES = 4,
  localparam int unsigned CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr_wr,
  input  logic pulse_mode,
  output logic flag_q,
  output logic flag_nxt
);
  localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    flag_nxt = flag_q;
    cnt_nxt  = cnt_q;
    if (evt) begin
      flag_nxt = 1'b1;
      cnt_nxt  = RELOAD;
    end else if (clr_wr) begin
      flag_nxt = 1'b0;
      cnt_nxt  = '0;
    end else if (pulse_mode && flag_q) begin
      if (cnt_q == '0) flag_nxt = 1'b0;
      else cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_nxt;
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pig_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_64hz,
  input  logic             tick_sec,
  input  logic             carry_min,
  input  logic             carry_hour,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq_out
);
  ctl_t ctl_q, ctl_nxt;
  logic ctl_wr, clr_wr, evt, flag_q, flag_nxt;

  assign ctl_wr = wr_en & reg_sel;
  assign clr_wr = wr_en & ~reg_sel & ~wdata[FLAG_BIT];

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_wr) ctl_nxt = ctl_t'(wdata);
  end

  pig_tick_select #(.NSRC(4)) u_sel (
    .ctl_wr (ctl_wr),
    .period (ctl_q.period),
    .ticks  ({carry_hour, carry_min, tick_sec, tick_64hz}),
    .evt    (evt)
  );

  pig_flag_core #(.PULSE_CYCLES(PULSE_CYCLES)) u_flag (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .clr_wr     (clr_wr),
    .pulse_mode (ctl_q.pulse_mode),
    .flag_q     (flag_q),
    .flag_nxt   (flag_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      irq_out <= 1'b0;
      rdata   <= '0;
    end else begin
      ctl_q   <= ctl_nxt;
      irq_out <= flag_nxt & ~ctl_nxt.mask;
      if (rd_en) begin
        if (reg_sel) rdata <= ctl_q;
        else rdata <= REG_W'({flag_q, 2'b00});
      end
    end
  end
endmodule

// File: rtl/pig_checker.sv
module pig_checker (
  input logic clk,
  input logic rst,
  input logic evt,
  input logic clr_wr,
  input logic flag,
  input logic pulse_mode,
  input logic mask,
  input logic irq_out
);
  AST_RISE_FROM_EVT: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(evt)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag && !pulse_mode && !clr_wr) |=> flag); // R2

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    mask |-> !irq_out); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> flag); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag); // R7
endmodule

bind periodic_irq_gen pig_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt        (evt),
  .clr_wr     (clr_wr),
  .flag       (flag_q),
  .pulse_mode (ctl_q.pulse_mode),
  .mask       (ctl_q.mask),
  .irq_out    (irq_out)
);

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;
  localparam int P = 4;
  logic clk = 0, rst = 1;
  logic [3:0] ticks = '0;
  logic wr_en = 0, rd_en = 0, reg_sel = 0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic irq_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  periodic_irq_gen #(.PULSE_CYCLES(P)) uut (
    .clk(clk), .rst(rst),
    .tick_64hz(ticks[0]), .tick_sec(ticks[1]),
    .carry_min(ticks[2]), .carry_hour(ticks[3]),
    .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [3:0] d, input logic [3:0] tk);
    wr_en = 1; reg_sel = sel; wdata = d; ticks = tk;
    cyc();
    wr_en = 0; ticks = '0;
  endtask

  task automatic tick(input logic [3:0] tk);
    ticks = tk;
    cyc();
    ticks = '0;
  endtask

  task automatic rd(input logic sel, output logic [3:0] v);
    rd_en = 1; reg_sel = sel;
    cyc();
    rd_en = 0;
    v = rdata;
  endtask

  task automatic flag_of(output int f);
    logic [3:0] v;
    rd(1'b0, v);
    f = v[2];
  endtask

  task automatic t_reset();
    logic [3:0] v; int f;
    chk(irq_out, 0, "R8 irq");
    rd(1'b1, v); chk(v, 0, "R8 ctl");
    flag_of(f); chk(f, 0, "R8 flag");
  endtask

  task automatic t_periods();
    int f;
    for (int s = 0; s < 4; s++) begin
      wr(1'b1, 4'(s << 2), 4'b0);
      for (int o = 0; o < 4; o++) if (o != s) tick(4'(1 << o));
      flag_of(f); chk(f, 0, "R1 other source");
      tick(4'(1 << s));
      chk(irq_out, 1, "R1 selected irq");
      flag_of(f); chk(f, 1, "R1 selected flag");
      wr(1'b0, 4'b0, 4'b0);
    end
  endtask

  task automatic t_latch();
    int f;
    wr(1'b1, 4'b0100, 4'b0);
    tick(4'b0010);
    repeat (10) cyc();
    chk(irq_out, 1, "R2 held");
    wr(1'b0, 4'b0100, 4'b0);
    flag_of(f); chk(f, 1, "R2 write one keeps");
    wr(1'b0, 4'b0000, 4'b0);
    chk(irq_out, 0, "R2 cleared irq");
    flag_of(f); chk(f, 0, "R2 cleared flag");
  endtask

  task automatic t_pulse();
    int hi;
    wr(1'b1, 4'b0010, 4'b0);
    tick(4'b0001);
    hi = 0;
    for (int k = 0; k < P + 3; k++) begin
      hi += irq_out;
      cyc();
    end
    chk(hi, P, "R3 width");
    tick(4'b0001);
    repeat (P - 2) cyc();
    tick(4'b0001);
    hi = 0;
    for (int k = 0; k < P + 3; k++) begin
      hi += irq_out;
      cyc();
    end
    chk(hi, P, "R9 restart width");
  endtask

  task automatic t_mask();
    int f;
    logic [3:0] v;
    wr(1'b1, 4'b0001, 4'b0);
    tick(4'b0001);
    chk(irq_out, 0, "R4 masked irq");
    flag_of(f); chk(f, 1, "R4 flag sets while masked");
    wr(1'b1, 4'b0000, 4'b0);
    chk(irq_out, 1, "R4 unmasked");
    rd(1'b1, v); chk(v, 0, "R5 ctl readback");
    rd(1'b0, v); chk(v, 4'b0100, "R5 status word");
    wr(1'b0, 4'b0, 4'b0);
  endtask

  task automatic t_write_tick();
    int f;
    wr(1'b1, 4'b0100, 4'b0);
    wr(1'b1, 4'b0100, 4'b0010);
    flag_of(f); chk(f, 0, "R6 tick at write dropped");
    tick(4'b0010);
    flag_of(f); chk(f, 1, "R6 next tick counted");
    wr(1'b0, 4'b0, 4'b0);
  endtask

  task automatic t_collide();
    wr(1'b1, 4'b0100, 4'b0);
    tick(4'b0010);
    wr(1'b0, 4'b0000, 4'b0010);
    chk(irq_out, 1, "R7 set wins");
    wr(1'b0, 4'b0000, 4'b0);
    chk(irq_out, 0, "R7 clear after");
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    t_reset();
    t_periods();
    t_latch();
    t_pulse();
    t_mask();
    t_write_tick();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule